// File: doc/BRIEF.md
# Three-Table Majority Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Every fetch cycle may present a fetch address. Three separate tables of 2-bit saturating counters are read together, each at its own index. The first table is indexed by address bits alone. The other two are indexed by the address mixed with an 8-bit global history of recent predictions. Each table contributes one vote, the most significant bit of its counter. The prediction is "taken" when at least two votes say taken. The prediction appears on a registered output one cycle after the lookup.

Each prediction also returns a small tag: the three table indices it used and the history value it was made under. The pipeline carries this tag with the branch. When the branch resolves, the tag comes back on the resolve port together with the actual outcome. The counters at those exact indices are then trained. A mispredicted branch also rebuilds the global history from its checkpoint.

Top module: `vote_branch_predictor`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value 01 and the global history is zero, so a lookup made right after reset predicts not-taken and reports history 0.
- R2: `predValid` is high in the cycle after a cycle with `lookupValid` high, and low in the cycle after a cycle with `lookupValid` low.
- R3: `predTaken` is 1 exactly when at least two of the three counters that were read hold a value of 2 or more.
- R4: With p = `lookupPc[9:2]` and h = history, the indices are t0 = p, t1 = p ^ h and t2 = p ^ {h[3:0], h[7:4]}. They are reported on `predIdx` with t0 in bits [7:0], t1 in [15:8] and t2 in [23:16].
- R5: A lookup reports the history it used on `predHist`. The history then shifts left, and the new prediction enters bit 0.
- R6: A resolve with `resolveMispredict` high loads the history with {`resolveHist[6:0]`, `resolveTaken`}. This takes priority over a shift from a lookup in the same cycle, and that lookup still uses the old history.
- R7: A resolve without a misprediction leaves the history unchanged.
- R8: Each resolve moves the three counters named by `resolveIdx` (same bit layout as `predIdx`) one step toward the outcome: +1 when taken, −1 when not taken. A counter stays at 3 on further taken updates and at 0 on further not-taken updates.
- R9: When an update and a lookup reach the same counter in the same cycle, the lookup sees the value from before the update. The update is not lost.
- R10: Cycles without a lookup or a misprediction leave the history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| lookupValid | input | 1 | Fetch address present this cycle |
| lookupPc | input | 32 | Fetch address |
| resolveValid | input | 1 | A branch outcome is reported this cycle |
| resolveTaken | input | 1 | Actual direction of the resolved branch |
| resolveMispredict | input | 1 | The resolved branch was mispredicted |
| resolveIdx | input | 24 | Table indices carried from the branch's prediction |
| resolveHist | input | 8 | History checkpoint carried from the branch's prediction |
| predValid | output | 1 | Prediction output is valid |
| predTaken | output | 1 | Majority prediction |
| predIdx | output | 24 | Indices used for this prediction |
| predHist | output | 8 | History in effect for this prediction |

## Verification
A corrupted counter changes the vote only when it flips one table's MSB while the other two tables disagree. The bench therefore sweeps every address index under many pinned history values after mixed training, so such a fault shows on `predTaken` within one lookup of the affected entry. A wrong history value shows up on the very next lookup, both in `predHist` and in the two hashed indices on `predIdx`. Saturation faults and write-versus-read ordering faults need several resolves in a row before they change a vote. The directed sequences are arranged to expose them within one or two cycles after that.

// File: rtl/bpv_pkg.sv
package bpv_pkg;
  localparam int NUM_TBL = 3;
  localparam int CNT_W = 2;

  typedef struct packed {
    logic upd;
    logic updTaken;
  } bpvStrobe_t;
endpackage

// File: rtl/bpv_tables.sv
module bpv_tables
  import bpv_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  bpvStrobe_t                      st,
  input  logic [NUM_TBL-1:0][IDX_W-1:0]   rdIdx,
  input  logic [NUM_TBL-1:0][IDX_W-1:0]   wrIdx,
  output logic [NUM_TBL-1:0]              voteBits
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'((1 << (CNT_W - 1)) - 1);

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    logic [CNT_W-1:0] ctr [DEPTH];
    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] nxt;

    assign cur = ctr[wrIdx[t]];

    always_comb begin
      nxt = cur;
      if (st.updTaken) begin
        if (cur != CNT_MAX) nxt = cur + 1'b1;
      end else begin
        if (cur != '0) nxt = cur - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) ctr[i] <= CNT_RST;
      end else if (st.upd) begin
        ctr[wrIdx[t]] <= nxt;
      end
    end

    // Old value is read even when a write targets the same entry (R9)
    assign voteBits[t] = ctr[rdIdx[t]][CNT_W-1];

    always_comb begin
      if (rstN && st.upd) begin
        a_r8_step: assert (st.updTaken ? (nxt == cur + 1'b1 || cur == CNT_MAX)
                                       : (nxt == cur - 1'b1 || cur == '0));
        a_r8_sat: assert (!(cur == CNT_MAX && st.updTaken) || nxt == CNT_MAX);
      end
    end
  end
endmodule

// File: rtl/bpv_ctrl.sv
module bpv_ctrl
  import bpv_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            lookupValid,
  input  logic [PC_W-1:0]                 lookupPc,
  input  logic                            resolveValid,
  input  logic                            resolveTaken,
  input  logic                            resolveMispredict,
  input  logic [NUM_TBL-1:0][IDX_W-1:0]   resolveIdx,
  input  logic [IDX_W-1:0]                resolveHist,
  input  logic [NUM_TBL-1:0]              voteBits,
  output bpvStrobe_t                      st,
  output logic [NUM_TBL-1:0][IDX_W-1:0]   rdIdx,
  output logic [NUM_TBL-1:0][IDX_W-1:0]   wrIdx,
  output logic                            predValid,
  output logic                            predTaken,
  output logic [NUM_TBL-1:0][IDX_W-1:0]   predIdx,
  output logic [IDX_W-1:0]                predHist
);
  localparam int HALF = IDX_W / 2;

  logic [IDX_W-1:0] hist;
  logic [IDX_W-1:0] pcIdx;
  logic             maj;
  logic             restore;
  logic             unusedPc;

  assign pcIdx    = lookupPc[IDX_W+1:2];
  assign unusedPc = ^{lookupPc[PC_W-1:IDX_W+2], lookupPc[1:0]};

  assign rdIdx[0] = pcIdx;
  assign rdIdx[1] = pcIdx ^ hist;
  assign rdIdx[2] = pcIdx ^ {hist[HALF-1:0], hist[IDX_W-1:HALF]};

  assign maj = (voteBits[0] & voteBits[1]) | (voteBits[0] & voteBits[2]) |
               (voteBits[1] & voteBits[2]);

  assign restore     = resolveValid && resolveMispredict;
  assign st.upd      = resolveValid;
  assign st.updTaken = resolveTaken;
  assign wrIdx       = resolveIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist      <= '0;
      predValid <= 1'b0;
      predTaken <= 1'b0;
      predIdx   <= '0;
      predHist  <= '0;
    end else begin
      predValid <= lookupValid;
      if (lookupValid) begin
        predTaken <= maj;
        predIdx   <= rdIdx;
        predHist  <= hist;
      end
      if (restore) hist <= {resolveHist[IDX_W-2:0], resolveTaken};
      else if (lookupValid) hist <= {hist[IDX_W-2:0], maj};
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> predValid);
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !predValid);
  a_r3_vote: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (predTaken == ($countones($past(voteBits)) >= 2)));
  a_r5_shift_in: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !restore) |=> (hist[0] == predTaken));
  a_r6_restore: assert property (@(posedge clk) disable iff (!rstN)
    restore |=> (hist == {$past(resolveHist[IDX_W-2:0]), $past(resolveTaken)}));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!lookupValid && !restore) |=> $stable(hist));
endmodule

// File: rtl/vote_branch_predictor.sv
module vote_branch_predictor
  import bpv_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lookupValid,
  input  logic [PC_W-1:0]            lookupPc,
  input  logic                       resolveValid,
  input  logic                       resolveTaken,
  input  logic                       resolveMispredict,
  input  logic [NUM_TBL*IDX_W-1:0]   resolveIdx,
  input  logic [IDX_W-1:0]           resolveHist,
  output logic                       predValid,
  output logic                       predTaken,
  output logic [NUM_TBL*IDX_W-1:0]   predIdx,
  output logic [IDX_W-1:0]           predHist
);
  bpvStrobe_t                     st;
  logic [NUM_TBL-1:0][IDX_W-1:0]  rdIdx;
  logic [NUM_TBL-1:0][IDX_W-1:0]  wrIdx;
  logic [NUM_TBL-1:0][IDX_W-1:0]  resIdxP;
  logic [NUM_TBL-1:0][IDX_W-1:0]  predIdxP;
  logic [NUM_TBL-1:0]             voteBits;

  assign resIdxP = resolveIdx;
  assign predIdx = predIdxP;

  bpv_ctrl #(.PC_W(PC_W), .IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupPc(lookupPc),
    .resolveValid(resolveValid), .resolveTaken(resolveTaken),
    .resolveMispredict(resolveMispredict), .resolveIdx(resIdxP),
    .resolveHist(resolveHist), .voteBits(voteBits),
    .st(st), .rdIdx(rdIdx), .wrIdx(wrIdx),
    .predValid(predValid), .predTaken(predTaken),
    .predIdx(predIdxP), .predHist(predHist)
  );

  bpv_tables #(.IDX_W(IDX_W)) i_tables (
    .clk(clk), .rstN(rstN), .st(st),
    .rdIdx(rdIdx), .wrIdx(wrIdx), .voteBits(voteBits)
  );
endmodule

// File: tb/test_vote_branch_predictor.sv
`timescale 1ns/1ps
module test_vote_branch_predictor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupPc = '0;
  logic        resolveValid = 1'b0;
  logic        resolveTaken = 1'b0;
  logic        resolveMispredict = 1'b0;
  logic [23:0] resolveIdx = '0;
  logic [7:0]  resolveHist = '0;
  logic        predValid;
  logic        predTaken;
  logic [23:0] predIdx;
  logic [7:0]  predHist;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  int mc [3][256];
  logic [7:0] mh;

  always #2 clk = ~clk;

  vote_branch_predictor i_vote_branch_predictor (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupPc(lookupPc),
    .resolveValid(resolveValid), .resolveTaken(resolveTaken),
    .resolveMispredict(resolveMispredict), .resolveIdx(resolveIdx),
    .resolveHist(resolveHist), .predValid(predValid), .predTaken(predTaken),
    .predIdx(predIdx), .predHist(predHist)
  );

  task automatic chk(input string tag, input logic [31:0] actV, input logic [31:0] expV);
    nChecks++;
    if (actV !== expV) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, actV, expV, $time);
    end
  endtask

  // Called at a negedge: drives one cycle, updates the model, checks at the next negedge
  task automatic cyc(input bit lv, input logic [31:0] pc, input bit rv, input bit rt,
                     input bit rm, input logic [23:0] ri, input logic [7:0] rh,
                     input string tg);
    logic [7:0] p, e0, e1, e2, eh;
    int votes;
    bit et;
    lookupValid = lv; lookupPc = pc; resolveValid = rv; resolveTaken = rt;
    resolveMispredict = rm; resolveIdx = ri; resolveHist = rh;
    p  = pc[9:2];
    e0 = p;
    e1 = p ^ mh;
    e2 = p ^ {mh[3:0], mh[7:4]};
    votes = int'(mc[0][e0] >= 2) + int'(mc[1][e1] >= 2) + int'(mc[2][e2] >= 2);
    et = (votes >= 2);
    eh = mh;
    if (rv) begin
      for (int t = 0; t < 3; t++) begin
        int ix;
        ix = int'(ri[t*8 +: 8]);
        if (rt && mc[t][ix] < 3) mc[t][ix]++;
        else if (!rt && mc[t][ix] > 0) mc[t][ix]--;
      end
    end
    if (rv && rm) mh = {rh[6:0], rt};
    else if (lv) mh = {mh[6:0], et};
    @(negedge clk);
    chk("R2", 32'(predValid), 32'(lv));
    if (lv) begin
      chk((tg == "") ? "R3" : tg, 32'(predTaken), 32'(et));
      chk("R4", 32'(predIdx), 32'({e2, e1, e0}));
      chk((tg == "") ? "R5" : tg, 32'(predHist), 32'(eh));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R2: watchdog actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 3; t++)
      for (int i = 0; i < 256; i++) mc[t][i] = 1;
    mh = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", 32'(predValid), 32'h0);

    // R1: right after reset every lookup predicts not-taken under history 0
    cyc(1, 32'h0000_0124, 0, 0, 0, '0, '0, "R1");
    chk("R1", 32'(predTaken), 32'h0);
    cyc(1, 32'h0000_03FC, 0, 0, 0, '0, '0, "R1");

    // R10: idle cycles keep history; R2 checked inside cyc
    for (int k = 0; k < 3; k++) cyc(0, '0, 0, 0, 0, '0, '0, "R10");
    cyc(1, 32'h0000_0040, 0, 0, 0, '0, '0, "R10");

    // R6: pin history to 0, then R8 saturation at index 0x33
    cyc(0, '0, 1, 0, 1, 24'hAAAAAA, 8'h00, "R6");
    for (int k = 0; k < 5; k++) cyc(0, '0, 1, 1, 0, 24'h333333, '0, "R8");
    cyc(0, '0, 1, 0, 0, 24'h333333, '0, "R8");
    // R7: the correct resolves above left history at 0
    cyc(1, 32'h0000_00CC, 1, 0, 1, 24'h000000, 8'h00, "R8");
    chk("R8", 32'(predTaken), 32'h1);
    chk("R7", 32'(predHist), 32'h0);

    // R9: lookup and not-taken update of the same entries in one cycle
    cyc(1, 32'h0000_00CC, 1, 0, 1, 24'h333333, 8'h00, "R9");
    chk("R9", 32'(predTaken), 32'h1);
    cyc(1, 32'h0000_00CC, 1, 0, 1, 24'h000000, 8'h00, "R9");
    chk("R9", 32'(predTaken), 32'h0);

    // R6: restore wins over the lookup shift in the same cycle
    cyc(1, 32'h0000_0200, 1, 1, 1, 24'h010203, 8'hC5, "R6");
    cyc(1, 32'h0000_0200, 0, 0, 0, '0, '0, "R6");
    chk("R6", 32'(predHist), 32'h8B);

    // Mixed random traffic trains the tables
    for (int k = 0; k < 6000; k++) begin
      bit lv, rv, rt, rm;
      lv = ($urandom % 4) != 0;
      rv = ($urandom % 2) != 0;
      rt = ($urandom % 2) != 0;
      rm = rv && (($urandom % 4) == 0);
      cyc(lv, $urandom, rv, rt, rm, 24'($urandom), 8'($urandom), "");
    end

    // Exhaustive address sweep under 16 pinned histories
    for (int hs = 0; hs < 16; hs++) begin
      logic [7:0] h;
      h = 8'(hs * 17 + 3);
      cyc(0, '0, 1, h[0], 1, 24'($urandom), {1'b0, h[7:1]}, "R6");
      for (int i = 0; i < 256; i++) begin
        logic [7:0] a;
        a = 8'(i);
        cyc(1, {22'($urandom), a, 2'b00}, 1, h[0], 1,
            {a ^ 8'h5A, a ^ 8'hC3, a ^ 8'h99}, {1'b0, h[7:1]}, "");
      end
    end

    cyc(0, '0, 0, 0, 0, '0, '0, "R2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule